// File: doc/BRIEF.md
# SPI controller with status flags

This block is a serial peripheral port seen by a processor through four 8-bit registers on a simple bus: control/status, configuration, clock divider and data. It acts as bus master or as a selected slave. As master it generates the serial clock from the system clock and shifts a frame of 1 to 8 bits out on MOSI, most significant bit first. At the same time it shifts the same number of bits in from MISO. As slave it follows an external serial clock while its active-low select input is held low.

Clock polarity and clock phase are both programmable, and the same rules apply in both roles. Completion, write collision, mode fault and receive overrun each have their own status flag. A single interrupt request combines these flags. The configuration register also shows which bit the current frame has reached. The completion flag has its own clearing rule: the processor must read the control register and then the data register, in that order.

Register map (bus_addr): 0 control/status, 1 configuration, 2 divider, 3 data. Control/status bits: [0] done, [1] write collision, [2] mode fault, [3] overrun, [4] busy (read-only), [5] selected as slave (read-only), [6] master enable, [7] interrupt enable. Bits 1 to 3 are cleared by writing 1 to them. Configuration bits: [0] phase, [1] polarity, [4:2] frame length minus one, [7:5] current bit position (read-only). bus_rdata always shows the register addressed by bus_addr. Read side effects happen only on a cycle with bus_rd high.

Top module: `spi_ctrl`

## Requirements
- R1: After reset, control/status reads 0x00, configuration reads 0x1C (8-bit frames, polarity 0, phase 0), the divider reads 0, data reads 0, irq is low, and none of the serial outputs is enabled (sck_oe, mosi_oe and miso_oe are low while ss_n is high).
- R2: In master mode, a data write while not busy starts a frame of L bits (L = field + 1). MOSI carries bit L-1 first and bit 0 last. SCK toggles every D+1 clocks, where D is the divider value. Busy reads 1 for exactly 2·L·(D+1) cycles after the write edge.
- R3: SCK rests low when polarity is 1 and high when polarity is 0. It is at that level before and after every frame.
- R4: With phase 0, input bits are sampled on the first clock edge of each bit period. With phase 1, they are sampled on the second. The data register then reads the L received bits, right-aligned, with the upper bits zero.
- R5: The done flag is set when a frame ends. It clears only when the data register is read after a read of control/status that saw done set. A data read alone leaves done set.
- R6: A data write while a frame is in progress sets the write-collision flag. The frame in progress still shifts out its original data.
- R7: If ss_n goes low while master enable is set, the mode-fault flag is set, master enable is cleared and sck_oe and mosi_oe drop.
- R8: If a frame ends while the previous received data has not yet been read, the overrun flag is set.
- R9: irq is high exactly when interrupt enable is set and at least one of done, write collision, mode fault or overrun is set.
- R10: During a master frame, configuration bits [7:5] read the index of the bit period in progress, counting from 0 (the number of completed SCK edges divided by two).
- R11: With master enable clear and ss_n low, the block reads as selected and drives MISO, MSB first, with the data last written. It samples MOSI on the external SCK under the same polarity and phase rules. At the end of the frame it sets done and holds the received bits in the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| sck_out | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Serial clock drive enable |
| sck_in | input | 1 | External serial clock in slave mode |
| mosi_out | output | 1 | Master output data |
| mosi_oe | output | 1 | Master output enable |
| mosi_in | input | 1 | Data received in slave mode |
| miso_out | output | 1 | Slave output data |
| miso_oe | output | 1 | Slave output enable |
| miso_in | input | 1 | Data received in master mode |
| ss_n | input | 1 | Active-low slave select |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check four things: SCK sits at its idle level whenever a master is not shifting, a data write during a frame raises the collision flag, a select drop in master mode produces a fault and releases the drivers, and done and overrun change only for their stated causes. Only the bench's scenarios can show the rest. That covers the exact frame duration, the bit order on MOSI, the phase-dependent sampling of received bits, the live bit position, the read-order rule for clearing done, and slave operation under an external clock. The bench checks these against a timing model that predicts the SCK level on every clock and acts as the remote device.

// File: rtl/spi_ctrl.sv
module spi_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sck_out,
  output logic          sck_oe,
  input  logic          sck_in,
  output logic          mosi_out,
  output logic          mosi_oe,
  input  logic          mosi_in,
  output logic          miso_out,
  output logic          miso_oe,
  input  logic          miso_in,
  input  logic          ss_n,
  output logic          irq
);
  localparam int CW = $clog2(DW);

  logic          done, wcol, modf, ovr, master, ien, cpha, cpol;
  logic          armed, unread, busy, lvl, mo;
  logic [CW-1:0] lenm1;
  logic [DW-1:0] div, dcnt, sh, rx, txb;
  logic [CW:0]   ecnt;
  logic [2:0]    ss_q, sck_q;
  logic [1:0]    mosi_q;

  wire wr_ctl = bus_wr && bus_addr == 2'd0;
  wire wr_cfg = bus_wr && bus_addr == 2'd1;
  wire wr_div = bus_wr && bus_addr == 2'd2;
  wire wr_dat = bus_wr && bus_addr == 2'd3;
  wire rd_ctl = bus_rd && bus_addr == 2'd0;
  wire rd_dat = bus_rd && bus_addr == 2'd3;

  wire selected = !master && !ss_q[1];
  wire slv_busy = selected && ecnt != '0;
  wire busy_any = master ? busy : slv_busy;
  wire ss_fall  = ss_q[2] && !ss_q[1];
  wire ss_rise  = !ss_q[2] && ss_q[1];
  wire fault    = master && ss_fall;
  wire tick     = master && busy && dcnt == div;
  wire sck_edge = selected && (sck_q[1] ^ sck_q[2]);
  wire evt      = tick || sck_edge;
  wire smp      = evt && (ecnt[0] == cpha);
  wire drv      = evt && (ecnt[0] != cpha);
  wire fin      = evt && (ecnt == {lenm1, 1'b1});
  wire in_bit   = master ? miso_in : mosi_q[1];
  wire start    = wr_dat && master && !busy;
  wire slv_load = wr_dat && !master && !slv_busy;
  wire collide  = wr_dat && busy_any;

  logic [DW-1:0] fmask, nxt_sh, fin_rx;
  assign fmask  = (DW'(1) << ({1'b0, lenm1} + 1'b1)) - DW'(1);
  assign nxt_sh = {sh[DW-2:0], in_bit};
  assign fin_rx = (smp ? nxt_sh : sh) & fmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {done, wcol, modf, ovr, master, ien, cpha, cpol} <= '0;
      {armed, unread, busy, lvl, mo} <= '0;
      lenm1  <= CW'(DW - 1);
      div    <= '0;
      dcnt   <= '0;
      sh     <= '0;
      rx     <= '0;
      txb    <= '0;
      ecnt   <= '0;
      ss_q   <= '1;
      sck_q  <= '0;
      mosi_q <= '0;
    end else begin
      ss_q   <= {ss_q[1:0], ss_n};
      sck_q  <= {sck_q[1:0], sck_in};
      mosi_q <= {mosi_q[0], mosi_in};

      if (wr_cfg) begin
        cpha  <= bus_wdata[0];
        cpol  <= bus_wdata[1];
        lenm1 <= bus_wdata[2 +: CW];
      end
      if (wr_div) div <= bus_wdata;
      if (wr_ctl) begin
        ien    <= bus_wdata[7];
        master <= bus_wdata[6];
        if (bus_wdata[1]) wcol <= 1'b0;
        if (bus_wdata[2]) modf <= 1'b0;
        if (bus_wdata[3]) ovr  <= 1'b0;
        if (!bus_wdata[6]) begin
          busy <= 1'b0;
          lvl  <= 1'b0;
          ecnt <= '0;
        end
      end

      if (rd_ctl && done) armed <= 1'b1;
      if (rd_dat) begin
        unread <= 1'b0;
        if (armed) begin
          done  <= 1'b0;
          armed <= 1'b0;
        end
      end

      if (master && busy) dcnt <= (dcnt == div) ? '0 : dcnt + 1'b1;

      if (evt) begin
        if (master) lvl <= ~lvl;
        if (smp) sh <= nxt_sh;
        if (drv) mo <= sh[lenm1];
        ecnt <= fin ? '0 : ecnt + 1'b1;
      end

      if (!master && ss_fall) begin
        ecnt <= '0;
        sh   <= txb;
        mo   <= txb[lenm1];
      end
      if (!master && ss_rise) ecnt <= '0;

      if (fin) begin
        busy   <= 1'b0;
        rx     <= fin_rx;
        done   <= 1'b1;
        armed  <= 1'b0;
        unread <= 1'b1;
        if (unread && !rd_dat) ovr <= 1'b1;
        if (!master) begin
          sh <= txb;
          mo <= txb[lenm1];
        end
      end

      if (start) begin
        sh   <= bus_wdata;
        mo   <= bus_wdata[lenm1];
        busy <= 1'b1;
        dcnt <= '0;
        ecnt <= '0;
        lvl  <= 1'b0;
      end

      if (slv_load) begin
        txb <= bus_wdata;
        if (selected) begin
          sh <= bus_wdata;
          mo <= bus_wdata[lenm1];
        end
      end

      if (collide) wcol <= 1'b1;

      if (fault) begin
        modf   <= 1'b1;
        master <= 1'b0;
        busy   <= 1'b0;
        ecnt   <= '0;
        lvl    <= 1'b0;
      end
    end
  end

  assign sck_out  = lvl ^ ~cpol;
  assign sck_oe   = master;
  assign mosi_out = mo;
  assign mosi_oe  = master;
  assign miso_out = mo;
  assign miso_oe  = selected;
  assign irq      = ien && (done || wcol || modf || ovr);

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {ien, master, selected, busy_any, ovr, modf, wcol, done};
      2'd1:    bus_rdata = {ecnt[CW:1], lenm1, cpol, cpha};
      2'd2:    bus_rdata = div;
      default: bus_rdata = rx;
    endcase
  end

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && !busy) |-> (sck_out == !cpol));

  // R6
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3 && busy_any) |=> wcol);

  // R7
  mode_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (modf && !sck_oe && !mosi_oe));

  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(bus_rd && bus_addr == 2'd3));

  // R8
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(unread && done));
endmodule

// File: tb/spi_ctrl_test.sv
module spi_ctrl_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe, irq;
  logic sck_in = 0, mosi_in = 0, miso_in = 0, ss_n = 1;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  int mon_on = 0, m_w, m_len, m_div, m_cpol, m_cpha, m_lastk;
  logic [7:0] m_stx, m_cap;

  spi_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_out(sck_out), .sck_oe(sck_oe),
    .sck_in(sck_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe), .mosi_in(mosi_in),
    .miso_out(miso_out), .miso_oe(miso_oe), .miso_in(miso_in), .ss_n(ss_n), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin : model
    int e, k, b;
    if (mon_on != 0) begin
      e = cyc - m_w;
      k = e / (m_div + 1);
      if (k > 2 * m_len) k = 2 * m_len;
      chk("R3 sck level", sck_out, m_cpol ? (k % 2) : 1 - (k % 2));
      if (k != m_lastk) begin
        if (k > 0 && ((k - 1) % 2) == m_cpha) m_cap = {m_cap[6:0], mosi_out};
        m_lastk = k;
      end
      b = m_cpha ? (k >> 1) : ((k + 1) >> 1);
      if (b > m_len - 1) b = m_len - 1;
      miso_in = m_stx[m_len - 1 - b];
    end
  end

  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1; #1; d = bus_rdata;
    @(posedge clk); #1;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic start_frame(input logic [7:0] tx);
    m_lastk = 0; m_cap = 0;
    bus_addr = 3; bus_wdata = tx; bus_wr = 1;
    @(posedge clk); #1;
    m_w = cyc; mon_on = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic setup(input int cp, input int ph, input int len, input int dv, input logic [7:0] stx);
    bwr(1, {3'b0, 3'(len - 1), 1'(cp), 1'(ph)});
    bwr(2, 8'(dv));
    m_cpol = cp; m_cpha = ph; m_len = len; m_div = dv; m_stx = stx;
  endtask

  task automatic run_frame(input int cp, input int ph, input int len, input int dv,
                           input logic [7:0] tx, input logic [7:0] stx, input int col);
    logic [7:0] v, mask;
    int t;
    mask = 8'((16'd1 << len) - 1);
    setup(cp, ph, len, dv, stx);
    start_frame(tx);
    t = 2 * len * (dv + 1);
    if (col != 0) bwr(3, 8'hFF);
    if (dv > 0 && len >= 3) begin
      wait_until(m_w + 5 * (dv + 1));
      peek(1, v); chk("R10 bit position", v[7:5], 2);
    end
    wait_until(m_w + t - 1);
    peek(0, v); chk("R2 busy before last edge", v[4], 1);
    wait_until(m_w + t);
    peek(0, v); chk("R2 busy after last edge", v[4], 0);
    @(negedge clk); @(negedge clk);
    mon_on = 0;
    chk("R2 mosi bits", m_cap & mask, tx & mask);
    if (col != 0) begin
      peek(0, v); chk("R6 collision flag", v[1], 1);
      bwr(0, 8'h42);
    end
    brd(0, v); chk("R5 done set", v[0], 1);
    brd(3, v); chk("R4 received data", v, stx & mask);
    peek(0, v); chk("R5 done cleared", v[0], 0);
  endtask

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    peek(0, v); chk("R1 ctrl reset", v, 8'h00);
    peek(1, v); chk("R1 cfg reset", v, 8'h1C);
    peek(2, v); chk("R1 div reset", v, 8'h00);
    peek(3, v); chk("R1 data reset", v, 8'h00);
    chk("R1 outputs idle", {irq, sck_oe, mosi_oe, miso_oe}, 4'b0000);

    bwr(0, 8'h40);
    run_frame(0, 0, 8, 0, 8'hA5, 8'h3C, 0);
    run_frame(1, 1, 8, 2, 8'h96, 8'hC3, 0);
    run_frame(1, 0, 5, 1, 8'h13, 8'h0A, 0);
    run_frame(0, 1, 1, 0, 8'h01, 8'h00, 0);
    run_frame(0, 0, 8, 1, 8'h5A, 8'h81, 1);

    setup(0, 0, 4, 0, 8'h09);
    start_frame(8'h06);
    wait_until(m_w + 10);
    mon_on = 0;
    brd(3, v); chk("R4 data 4-bit", v, 8'h09);
    peek(0, v); chk("R5 data read alone keeps done", v[0], 1);
    brd(0, v);
    brd(3, v);
    peek(0, v); chk("R5 ctrl then data clears done", v[0], 0);

    setup(0, 0, 8, 0, 8'h11);
    start_frame(8'h22);
    wait_until(m_w + 18);
    start_frame(8'h33);
    wait_until(m_w + 18);
    mon_on = 0;
    peek(0, v); chk("R8 overrun flag", v[3], 1);
    brd(0, v); brd(3, v);
    bwr(0, 8'h48);
    peek(0, v); chk("R8 overrun cleared", v[3], 0);

    bwr(0, 8'hC0);
    chk("R9 irq low with no flag", irq, 0);
    start_frame(8'h44);
    wait_until(m_w + 18);
    mon_on = 0;
    chk("R9 irq on done", irq, 1);
    brd(0, v); brd(3, v);
    chk("R9 irq low after clear", irq, 0);

    ss_n = 0;
    repeat (5) @(negedge clk);
    peek(0, v);
    chk("R7 fault flag", v[2], 1);
    chk("R7 master dropped", v[6], 0);
    chk("R7 drivers released", {sck_oe, mosi_oe}, 2'b00);
    chk("R9 irq on fault", irq, 1);
    ss_n = 1;
    repeat (5) @(negedge clk);
    bwr(0, 8'h04);
    peek(0, v); chk("R7 fault cleared", v[2], 0);
    chk("R9 irq off", irq, 0);

    bwr(1, 8'h1E);
    bwr(3, 8'hB4);
    ss_n = 0;
    repeat (6) @(negedge clk);
    chk("R11 miso enabled", miso_oe, 1);
    peek(0, v); chk("R11 selected bit", v[5], 1);
    for (int i = 0; i < 8; i++) begin
      chk("R11 miso bit", miso_out, (8'hB4 >> (7 - i)) & 1);
      mosi_in = (8'h6D >> (7 - i)) & 1;
      repeat (4) @(negedge clk);
      sck_in = 1;
      repeat (6) @(negedge clk);
      sck_in = 0;
      repeat (6) @(negedge clk);
    end
    peek(0, v); chk("R11 done in slave", v[0], 1);
    brd(3, v); chk("R11 slave received", v, 8'h6D);
    ss_n = 1;
    repeat (5) @(negedge clk);
    chk("R11 miso released", miso_oe, 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R2 actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule